// File: doc/BRIEF.md
# Peak-Current PWM Gate Latch

This block is the digital control core of a peak-current-mode switching regulator. It runs from a fast system clock and drives a single gate-enable output for the power switch. An external switching clock, a peak-current comparator output and an over-temperature sensor output enter as asynchronous digital inputs. Each of them passes through a two-flop synchronizer.

On the selected edge of the synchronized switching clock, a set/reset latch turns the gate on. When the comparator reports that the switch current has reached its programmed peak, the latch turns the gate off. A blanking counter ignores comparator trips for a fixed number of system cycles after each turn-on. This masks the turn-on current spike and sets a minimum on-pulse.

A strap selects whether the rising or the falling switching-clock edge starts a cycle; the falling edge is the default. A second strap decides whether an over-temperature condition forces the gate off. The over-temperature condition is always reported on an open-drain style flag. That flag is modelled as an output enable together with a drive value that is always low.

Top module: `pwm_cm_latch`

## Requirements
- R1: While rst_ni is low, gate_o, flag_oe_o and flag_dat_o are all 0. Asserting rst_ni low while the gate is on turns gate_o off without waiting for a clock edge.
- R2: With edge_sel_i = 1, a falling transition of ext_clk_i turns gate_o on. gate_o is high after the third rising clk_i edge following the transition; two of those edges are synchronizer stages and one is the latch. A rising transition has no effect.
- R3: With edge_sel_i = 0, a rising transition of ext_clk_i turns gate_o on with the same three-edge latency. A falling transition has no effect.
- R4: Once blanking has ended, a high trip_i turns gate_o off on the third rising clk_i edge after trip_i rises. A trip that rises d system cycles after the turn-on transition therefore gives an on-pulse of d cycles, provided d is at least BLANK_CYC.
- R5: For BLANK_CYC cycles after turn-on, trip_i is ignored. A trip that is already high, or that rises early, gives an on-pulse of exactly BLANK_CYC cycles.
- R6: A selected edge that arrives while gate_o is already on is ignored. In particular, it does not restart the blanking window.
- R7: If a qualified trip and a selected edge reach the latch in the same cycle while the gate is on, the trip wins. The gate turns off and stays off until a later selected edge.
- R8: With therm_off_i = 0, a high hot_i forces gate_o low on the third rising clk_i edge after it rises, and keeps it low. Selected edges that arrive during the fault are discarded. After hot_i falls, the gate stays off until the next selected edge.
- R9: With therm_off_i = 1, hot_i has no effect on gate_o.
- R10: flag_oe_o follows hot_i after the two synchronizer stages, whatever the value of therm_off_i. flag_dat_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External switching clock (asynchronous) |
| edge_sel_i | input | 1 | Turn-on edge strap: 1 = falling, 0 = rising |
| trip_i | input | 1 | Peak-current comparator output (asynchronous) |
| hot_i | input | 1 | Over-temperature sensor output (asynchronous) |
| therm_off_i | input | 1 | 1 disables thermal shutdown of the gate |
| gate_o | output | 1 | Power switch gate enable |
| flag_oe_o | output | 1 | Over-temperature flag output enable (pull low) |
| flag_dat_o | output | 1 | Over-temperature flag drive value, always 0 |

## Verification
The bench sweeps the trip arrival time from zero cycles to well past the blanking window, for both edge polarities. A design that mis-sized its counter would show pulses one cycle too short or too long, and a design that ignored the strap would fail to start on the chosen edge. Extra set edges are sent both inside the blanking window and in the same cycle as a qualified trip. A latch that re-armed its blanking counter would stretch the pulse, and one that gave priority to the set edge would never turn off. The thermal test sends a selected edge during the fault and then checks that the gate stays off after the fault clears. A design that remembered the edge, or that resumed as soon as the fault ended, would show a stray pulse.

// File: rtl/pwm_latch_pkg.sv
package pwm_latch_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pwm_edge_det.sv
module pwm_edge_det
  import pwm_latch_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_pol_e pol_i,
  output logic      pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    unique case (pol_i)
      EDGE_FALL: pulse_o = prev_q & ~lvl_i;
      default:   pulse_o = lvl_i & ~prev_q;
    endcase
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned BLANK_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic trip_i,
  input  logic fault_i,
  output logic gate_o,
  output logic blank_done_o
);
  localparam int unsigned CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);

  logic [CW-1:0] blank_q;
  logic          gate_q;

  assign blank_done_o = (blank_q == '0);

  // priority: fault, qualified trip, set (only from off), count down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      blank_q <= '0;
    end else if (fault_i) begin
      gate_q  <= 1'b0;
      blank_q <= '0;
    end else if (gate_q && trip_i && blank_done_o) begin
      gate_q  <= 1'b0;
    end else if (set_i && !gate_q) begin
      gate_q  <= 1'b1;
      blank_q <= CW'(BLANK_CYC - 1);
    end else if (!blank_done_o) begin
      blank_q <= blank_q - 1'b1;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/pwm_cm_latch.sv
module pwm_cm_latch
  import pwm_latch_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic edge_sel_i,
  input  logic trip_i,
  input  logic hot_i,
  input  logic therm_off_i,
  output logic gate_o,
  output logic flag_oe_o,
  output logic flag_dat_o
);
  logic [2:0] raw, syn;
  logic       ext_s, trip_s, hot_s;
  logic       set_pulse, fault, blank_done;

  assign raw = {hot_i, trip_i, ext_clk_i};

  pwm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {hot_s, trip_s, ext_s} = syn;

  pwm_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ext_s),
    .pol_i  (edge_pol_e'(edge_sel_i)),
    .pulse_o(set_pulse)
  );

  assign fault = hot_s & ~therm_off_i;

  pwm_core #(.BLANK_CYC(BLANK_CYC)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_pulse),
    .trip_i      (trip_s),
    .fault_i     (fault),
    .gate_o      (gate_o),
    .blank_done_o(blank_done)
  );

  // open-drain model: enable pulls low
  assign flag_oe_o  = hot_s;
  assign flag_dat_o = 1'b0;
endmodule

// File: rtl/pwm_cm_latch_chk.sv
module pwm_cm_latch_chk #(
  parameter int unsigned BLANK_CYC = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gate_o,
  input logic set_pulse,
  input logic trip_s,
  input logic fault,
  input logic blank_done
);
  localparam int unsigned LW = $clog2(BLANK_CYC + 2) + 1;
  localparam logic [LW-1:0] LMAX = '1;

  logic [LW-1:0] on_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           on_len <= '0;
    else if (!gate_o)      on_len <= '0;
    else if (on_len != LMAX) on_len <= on_len + 1'b1;
  end

  // R8
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> !gate_o);

  // R2
  set_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pulse && !gate_o && !fault) |=> gate_o);

  // R7
  trip_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && trip_s && blank_done && !fault) |=> !gate_o);

  // R5
  min_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_o) && !$past(fault)) |-> ($past(on_len) >= LW'(BLANK_CYC - 1)));

  // R6
  no_retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && set_pulse && !blank_done && !fault) |=> gate_o);
endmodule

bind pwm_cm_latch pwm_cm_latch_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gate_o    (gate_o),
  .set_pulse (set_pulse),
  .trip_s    (trip_s),
  .fault     (fault),
  .blank_done(blank_done)
);

// File: tb/pwm_cm_latch_bench.sv
module pwm_cm_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 5;
  localparam int NVEC       = 8;
  localparam int WD_CYC     = 20000;
  // stimulus table: edge select and trip delay (cycles after the turn-on transition)
  localparam int VSEL [NVEC] = '{1, 0, 1, 0, 1, 0, 1, 0};
  localparam int VDLY [NVEC] = '{8, 8, 0, 2, 5, 12, 6, 4};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_clk = 1'b1, edge_sel = 1'b1, trip = 1'b0, hot = 1'b0, therm_off = 1'b0;
  logic gate, flag_oe, flag_dat;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cm_latch #(.BLANK_CYC(BLANK)) u_pwm_cm_latch (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ext_clk_i  (ext_clk),
    .edge_sel_i (edge_sel),
    .trip_i     (trip),
    .hot_i      (hot),
    .therm_off_i(therm_off),
    .gate_o     (gate),
    .flag_oe_o  (flag_oe),
    .flag_dat_o (flag_dat)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_pulse(input logic sel, input int d, output int first, output int len);
    edge_sel = sel;
    ext_clk  = sel;
    trip     = 1'b0;
    repeat (6) @(negedge clk);
    ext_clk = ~sel;
    if (d == 0) trip = 1'b1;
    first = -1;
    len   = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (gate) begin
        if (first < 0) first = k;
        len++;
      end
      if (k == d) trip = 1'b1;
    end
    trip = 1'b0;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0 (run hung)", WD_CYC);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first, len, exp_len;
    int g7, g8, f6, f7, g14, g30, f30;

    // R1 reset state, hot high during reset
    hot = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 gate in reset", int'(gate), 0);
    check("R1 flag_oe in reset", int'(flag_oe), 0);
    check("R1 flag_dat in reset", int'(flag_dat), 0);
    hot = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R2/R3 latency, R4 trip, R5 blanking
    for (int v = 0; v < NVEC; v++) begin
      run_pulse(VSEL[v][0], VDLY[v], first, len);
      exp_len = (VDLY[v] > BLANK) ? VDLY[v] : BLANK;
      check(VSEL[v] != 0 ? "R2 turn-on latency falling" : "R3 turn-on latency rising", first, 3);
      check(VDLY[v] >= BLANK ? "R4 pulse length" : "R5 blanked pulse length", len, exp_len);
    end

    // R2/R3 wrong edge ignored: falling transition while rising selected
    edge_sel = 1'b0; ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    len = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (gate) len++;
    end
    check("R3 falling edge ignored", len, 0);

    // R6 retrigger during blanking must not stretch the pulse
    edge_sel = 1'b1; ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0; trip = 1'b1;
    len = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (gate) len++;
      if (k == 1) ext_clk = 1'b1;
      if (k == 2) ext_clk = 1'b0;
    end
    trip = 1'b0;
    check("R6 retrigger ignored", len, BLANK);

    // R7 trip and set edge reach latch together
    ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    len = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (gate) len++;
      if (k == 6) ext_clk = 1'b1;
      if (k == 7) begin ext_clk = 1'b0; trip = 1'b1; end
    end
    trip = 1'b0;
    check("R7 trip beats set", len, 7);

    // R8 thermal fault with shutdown enabled; R10 flag
    therm_off = 1'b0; ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    len = 0; g7 = 0; g8 = 0; f6 = 0; f7 = 0; g14 = 0; g30 = 0; f30 = 0;
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (gate) len++;
      if (k == 6)  f6 = int'(flag_oe);
      if (k == 7)  begin g7 = int'(gate); f7 = int'(flag_oe); end
      if (k == 8)  g8 = int'(gate);
      if (k == 14) g14 = int'(gate);
      if (k == 30) begin g30 = int'(gate); f30 = int'(flag_oe); end
      if (k == 5)  hot = 1'b1;
      if (k == 10) ext_clk = 1'b1;
      if (k == 12) ext_clk = 1'b0;
      if (k == 20) hot = 1'b0;
    end
    check("R8 gate before fault reaches latch", g7, 1);
    check("R8 gate forced off", g8, 0);
    check("R8 edge during fault discarded", g14, 0);
    check("R8 no resume after clear", g30, 0);
    check("R8 total on cycles", len, 5);
    check("R10 flag not yet synced", f6, 0);
    check("R10 flag asserted", f7, 1);
    check("R10 flag released", f30, 0);
    check("R10 flag_dat low", int'(flag_dat), 0);
    run_pulse(1'b1, 8, first, len);
    check("R8 resume on next edge", len, 8);

    // R9 shutdown disabled: hot ignored, flag still reports
    therm_off = 1'b1; hot = 1'b1;
    run_pulse(1'b1, 8, first, len);
    check("R9 pulse unaffected by hot", len, 8);
    check("R10 flag with shutdown disabled", int'(flag_oe), 1);
    check("R10 flag_dat low while flagging", int'(flag_dat), 0);
    hot = 1'b0; therm_off = 1'b0;

    // R1 asynchronous reset mid-pulse
    edge_sel = 1'b1; ext_clk = 1'b1;
    repeat (6) @(negedge clk);
    ext_clk = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 gate on before reset", int'(gate), 1);
    #1 rst_ni = 1'b0;
    #1 check("R1 reset drops gate", int'(gate), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule